// File: doc/BRIEF.md
# CAN Multi-Buffer Receive Allocator

This block sits behind a CAN receiver that has already decoded a frame. It places each frame into one of 32 message buffers. Each buffer carries a programmable buffer class, a reference identifier, an identifier format bit, a selector for one of four acceptance masks, a data-new flag and an interrupt-enable flag. Buffers that share a class and a masked identifier act as one receive group. No grouping register exists. A burst of matching frames fills the group from its lowest-numbered buffer upward, and no frame overwrites an earlier one that is still unread.

Frames are judged in the cycle they are offered. The outcome appears one cycle later as either a stored pulse, with the written buffer index, or a dropped pulse. A per-buffer interrupt pulse fires only when the written buffer has its interrupt enable set. Setting the enable on a group's last buffer signals that the group is full. Setting it on the second-to-last buffer warns that the group is close to overflowing. The host programs buffers and masks, reads any buffer through a combinational read port, and releases a buffer by pulsing its data-new clear bit.

Top module: `can_rxgrp_alloc`

## Requirements
- R1: After reset every buffer has class 0 (disabled), every data-new flag is clear, every mask is 0, and rx_stored, rx_dropped and rx_irq are 0.
- R2: A frame matches a buffer when the buffer class is non-zero and the format bits are equal. The identifiers must also be equal on every bit where the selected mask holds 0. A mask bit of 1 means "ignore". A standard frame (rx_ide=0) compares bits [10:0] only. An extended frame (rx_ide=1) compares bits [28:0].
- R3: A frame is written to the lowest-indexed buffer that matches, has its data-new flag clear, and belongs to the owning class. Group members need not be adjacent.
- R4: Storing a frame sets that buffer's data-new flag. It also records the frame's identifier, format bit, DLC and 8 data bytes, which the read port returns. A buffer whose flag is set is never written.
- R5: Storage does not wrap. When no eligible buffer is free, the frame is dropped and no data-new flag changes.
- R6: The owning class is the class of the lowest-indexed matching buffer, whatever its data-new flag. Buffers of any other class never receive the frame, even when they match and are free.
- R7: rx_irq pulses for one cycle, in the written buffer's bit only, and only when that buffer's interrupt enable is 1.
- R8: For each cycle with rx_valid=1, exactly one of rx_stored or rx_dropped pulses in the next cycle. rx_idx carries the written index with rx_stored.
- R9: A dn_clr bit clears that buffer's data-new flag at the next edge, and the buffer rejoins its group at its original position. A frame offered in the same cycle as a clear still sees the flag as set. A store into a buffer in the same cycle as its clear leaves the flag set.
- R10: A buffer configuration write replaces that buffer's settings and clears its data-new flag. This write takes precedence over a same-cycle store into the same buffer. A mask write replaces the selected mask.
- R11: A frame that matches no buffer is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Buffer configuration write strobe |
| cfg_idx | input | 5 | Buffer index for the configuration write |
| cfg_type | input | 2 | Buffer class (0 disables the buffer) |
| cfg_id | input | 29 | Reference identifier |
| cfg_ide | input | 1 | Reference format: 1 = extended |
| cfg_msel | input | 2 | Acceptance mask selector |
| cfg_ie | input | 1 | Interrupt enable |
| mask_we | input | 1 | Mask write strobe |
| mask_idx | input | 2 | Mask index for the mask write |
| mask_val | input | 29 | Mask value (1 = ignore bit) |
| dn_clr | input | 32 | Per-buffer data-new clear pulses |
| rx_valid | input | 1 | Decoded frame present |
| rx_id | input | 29 | Frame identifier |
| rx_ide | input | 1 | Frame format: 1 = extended |
| rx_dlc | input | 4 | Frame data length code |
| rx_data | input | 64 | Frame data bytes |
| rd_idx | input | 5 | Read port buffer index |
| rd_dn | output | 1 | Data-new flag of the read buffer |
| rd_id | output | 29 | Stored identifier of the read buffer |
| rd_ide | output | 1 | Stored format bit of the read buffer |
| rd_dlc | output | 4 | Stored DLC of the read buffer |
| rd_data | output | 64 | Stored data of the read buffer |
| rx_stored | output | 1 | Frame stored pulse |
| rx_dropped | output | 1 | Frame discarded pulse |
| rx_idx | output | 5 | Index written, valid with rx_stored |
| rx_irq | output | 32 | Per-buffer reception interrupt pulses |

## Verification
Two pairs of operations can land in the same edge. In the first, the host clears a data-new flag in the very cycle a frame arrives. In the second, the host rewrites a buffer's configuration while a frame is being stored into it. The bench provokes the first pair on purpose: it clears the middle member of a full group together with a new frame, and expects a drop. A follow-up frame must then land in the freed slot. The random phase mixes clear pulses with frames on every cycle. A behavioural model, which applies "old flags decide, store beats clear, configuration beats both", judges the outcome and the read-port contents cycle by cycle.

// File: rtl/can_mbuf_pkg.sv
package can_mbuf_pkg;

    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int TYPE_W = 2;
    localparam int MSEL_W = 2;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    localparam logic [TYPE_W-1:0] CLASS_OFF = '0;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [TYPE_W-1:0] btype;
        logic [ID_W-1:0]   id;
        logic              ide;
        logic [MSEL_W-1:0] msel;
        logic              ie;
    } bufcfg_t;

    // Bits that take part in the compare for a given frame format and mask.
    function automatic logic [ID_W-1:0] care_bits(logic ide, logic [ID_W-1:0] mask);
        logic [ID_W-1:0] c;
        c = ~mask;
        if (!ide) c &= {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
        return c;
    endfunction

    function automatic logic id_hit(frame_t f, bufcfg_t c, logic [ID_W-1:0] mask);
        return (c.btype != CLASS_OFF) && (c.ide == f.ide) &&
               (((f.id ^ c.id) & care_bits(f.ide, mask)) == '0);
    endfunction

endpackage

// File: rtl/can_mbuf_prio.sv
module can_mbuf_prio #(
    parameter int N = 32,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/can_mbuf_match.sv
module can_mbuf_match
    import can_mbuf_pkg::*;
#(
    parameter int NBUF  = 32,
    parameter int NMASK = 4
) (
    input  can_mbuf_pkg::frame_t                     frm,
    input  can_mbuf_pkg::bufcfg_t [NBUF-1:0]         cfg,
    input  logic [NMASK-1:0][can_mbuf_pkg::ID_W-1:0] masks,
    output logic [NBUF-1:0]                          hit
);
    for (genvar g = 0; g < NBUF; g++) begin : g_cmp
        assign hit[g] = id_hit(frm, cfg[g], masks[cfg[g].msel]);
    end
endmodule

// File: rtl/can_mbuf_table.sv
module can_mbuf_table
    import can_mbuf_pkg::*;
#(
    parameter int NBUF  = 32,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [IDX_W-1:0]                  cfg_idx,
    input  can_mbuf_pkg::bufcfg_t             cfg_new,
    input  logic [NBUF-1:0]                   dn_clr,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  can_mbuf_pkg::frame_t              wr_frm,
    input  logic [IDX_W-1:0]                  rd_idx,
    output can_mbuf_pkg::bufcfg_t [NBUF-1:0]  cfg_q,
    output logic [NBUF-1:0]                   dn_q,
    output can_mbuf_pkg::frame_t              rd_frm,
    output logic                              rd_dn
);
    frame_t slot_q [NBUF];

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic cfg_hit, wr_hit;
        assign cfg_hit = cfg_we && (cfg_idx == IDX_W'(g));
        assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
                dn_q[g]  <= 1'b0;
                slot_q[g] <= '0;
            end else begin
                if (wr_hit) slot_q[g] <= wr_frm;
                if (cfg_hit) begin
                    cfg_q[g] <= cfg_new;
                    dn_q[g]  <= 1'b0;
                end else if (wr_hit) begin
                    dn_q[g]  <= 1'b1;
                end else if (dn_clr[g]) begin
                    dn_q[g]  <= 1'b0;
                end
            end
        end
    end

    assign rd_frm = slot_q[rd_idx];
    assign rd_dn  = dn_q[rd_idx];

    // R4: a store that is not overridden by a configuration write leaves the flag set
    a_r4_dn_after_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(cfg_we && cfg_idx == wr_idx)) |=> dn_q[$past(wr_idx)]);

    // R10: a configuration write always leaves the flag clear
    a_r10_cfg_clears_dn: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !dn_q[$past(cfg_idx)]);
endmodule

// File: rtl/can_rxgrp_alloc.sv
module can_rxgrp_alloc
    import can_mbuf_pkg::*;
#(
    parameter int NBUF   = 32,
    parameter int NMASK  = 4,
    parameter int IDX_W  = $clog2(NBUF),
    parameter int MIDX_W = $clog2(NMASK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [1:0]         cfg_type,
    input  logic [28:0]        cfg_id,
    input  logic               cfg_ide,
    input  logic [1:0]         cfg_msel,
    input  logic               cfg_ie,
    input  logic               mask_we,
    input  logic [MIDX_W-1:0]  mask_idx,
    input  logic [28:0]        mask_val,
    input  logic [NBUF-1:0]    dn_clr,
    input  logic               rx_valid,
    input  logic [28:0]        rx_id,
    input  logic               rx_ide,
    input  logic [3:0]         rx_dlc,
    input  logic [63:0]        rx_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_dn,
    output logic [28:0]        rd_id,
    output logic               rd_ide,
    output logic [3:0]         rd_dlc,
    output logic [63:0]        rd_data,
    output logic               rx_stored,
    output logic               rx_dropped,
    output logic [IDX_W-1:0]   rx_idx,
    output logic [NBUF-1:0]    rx_irq
);
    logic [NMASK-1:0][ID_W-1:0] mask_q;
    bufcfg_t [NBUF-1:0]         cfg_q;
    logic [NBUF-1:0]            dn_q;
    logic [NBUF-1:0]            hit, elig;
    frame_t                     frm, rd_frm;
    bufcfg_t                    cfg_new;
    logic                       own_found, tgt_found, wr_en;
    logic [IDX_W-1:0]           own_idx, tgt_idx;
    logic [TYPE_W-1:0]          own_type;

    assign frm     = '{id: rx_id, ide: rx_ide, dlc: rx_dlc, data: rx_data};
    assign cfg_new = '{btype: cfg_type, id: cfg_id, ide: cfg_ide, msel: cfg_msel, ie: cfg_ie};

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q[mask_idx] <= mask_val;
    end

    can_mbuf_match #(.NBUF(NBUF), .NMASK(NMASK)) u_match (
        .frm(frm), .cfg(cfg_q), .masks(mask_q), .hit(hit)
    );

    // First stage: the lowest matching buffer decides the owning class.
    can_mbuf_prio #(.N(NBUF), .W(IDX_W)) u_owner (
        .req(hit), .found(own_found), .idx(own_idx)
    );
    assign own_type = cfg_q[own_idx].btype;

    for (genvar g = 0; g < NBUF; g++) begin : g_elig
        assign elig[g] = rx_valid && own_found && hit[g] && !dn_q[g] &&
                         (cfg_q[g].btype == own_type);
    end

    // Second stage: the lowest free member of that class takes the frame.
    can_mbuf_prio #(.N(NBUF), .W(IDX_W)) u_target (
        .req(elig), .found(tgt_found), .idx(tgt_idx)
    );
    assign wr_en = tgt_found;

    can_mbuf_table #(.NBUF(NBUF), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_new(cfg_new),
        .dn_clr(dn_clr),
        .wr_en(wr_en), .wr_idx(tgt_idx), .wr_frm(frm),
        .rd_idx(rd_idx),
        .cfg_q(cfg_q), .dn_q(dn_q), .rd_frm(rd_frm), .rd_dn(rd_dn)
    );

    assign rd_id   = rd_frm.id;
    assign rd_ide  = rd_frm.ide;
    assign rd_dlc  = rd_frm.dlc;
    assign rd_data = rd_frm.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_stored  <= 1'b0;
            rx_dropped <= 1'b0;
            rx_idx     <= '0;
            rx_irq     <= '0;
        end else begin
            rx_stored  <= wr_en;
            rx_dropped <= rx_valid && !wr_en;
            rx_idx     <= wr_en ? tgt_idx : '0;
            rx_irq     <= '0;
            if (wr_en && cfg_q[tgt_idx].ie) rx_irq[tgt_idx] <= 1'b1;
        end
    end

    // R8: one outcome per offered frame, and never without one
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(rx_stored && rx_dropped));
    a_r8_follows_valid: assert property (@(posedge clk) disable iff (rst)
        (rx_stored || rx_dropped) |-> $past(rx_valid));
    // R7: interrupts only accompany a store, one buffer at a time
    a_r7_irq_needs_store: assert property (@(posedge clk) disable iff (rst)
        (|rx_irq) |-> rx_stored);
    a_r7_irq_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_irq));
    // R4: the chosen buffer was free
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !dn_q[tgt_idx]);
    // R6: the chosen buffer belongs to the owning class
    a_r6_class_kept: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (cfg_q[tgt_idx].btype == cfg_q[own_idx].btype));
endmodule

// File: tb/can_rxgrp_alloc_bench.sv
module can_rxgrp_alloc_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0;
    logic [4:0]  cfg_idx = 0;
    logic [1:0]  cfg_type = 0;
    logic [28:0] cfg_id = 0;
    logic        cfg_ide = 0;
    logic [1:0]  cfg_msel = 0;
    logic        cfg_ie = 0;
    logic        mask_we = 0;
    logic [1:0]  mask_idx = 0;
    logic [28:0] mask_val = 0;
    logic [31:0] dn_clr = 0;
    logic        rx_valid = 0;
    logic [28:0] rx_id = 0;
    logic        rx_ide = 0;
    logic [3:0]  rx_dlc = 0;
    logic [63:0] rx_data = 0;
    logic [4:0]  rd_idx = 0;
    logic        rd_dn, rd_ide, rx_stored, rx_dropped;
    logic [28:0] rd_id;
    logic [3:0]  rd_dlc;
    logic [63:0] rd_data;
    logic [4:0]  rx_idx;
    logic [31:0] rx_irq;

    can_rxgrp_alloc u_can_rxgrp_alloc (.*);

    always #10 clk = ~clk;   // 50 MHz

    int compared = 0, mismatched = 0, cycles = 0;
    bit live = 0, done = 0;

    // ---------------- behavioural reference ----------------
    logic [1:0]  m_type [32];
    logic [28:0] m_cid [32];
    logic        m_cide [32];
    logic [1:0]  m_msel [32];
    logic        m_ie [32];
    logic [28:0] m_mask [4];
    logic        m_dn [32];
    logic [28:0] m_rid [32];
    logic        m_ride [32];
    logic [3:0]  m_dlc [32];
    logic [63:0] m_data [32];
    logic        e_stored, e_dropped;
    logic [4:0]  e_idx;
    logic [31:0] e_irq;
    int own, tgt;

    function automatic bit mmatch(int i, logic [28:0] id, logic ide);
        logic [28:0] care;
        care = ~m_mask[m_msel[i]];
        if (!ide) care &= 29'h7FF;
        return (m_type[i] != 0) && (m_cide[i] == ide) && (((id ^ m_cid[i]) & care) == 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) begin
                m_type[i] = 0; m_cid[i] = 0; m_cide[i] = 0; m_msel[i] = 0; m_ie[i] = 0;
                m_dn[i] = 0; m_rid[i] = 0; m_ride[i] = 0; m_dlc[i] = 0; m_data[i] = 0;
            end
            for (int k = 0; k < 4; k++) m_mask[k] = 0;
            e_stored = 0; e_dropped = 0; e_idx = 0; e_irq = 0;
        end else begin
            e_stored = 0; e_dropped = 0; e_idx = 0; e_irq = 0;
            own = -1; tgt = -1;
            if (rx_valid) begin
                for (int i = 0; i < 32; i++)
                    if (own < 0 && mmatch(i, rx_id, rx_ide)) own = i;
                if (own >= 0)
                    for (int i = 0; i < 32; i++)
                        if (tgt < 0 && mmatch(i, rx_id, rx_ide) && !m_dn[i] && m_type[i] == m_type[own]) tgt = i;
                if (tgt < 0) e_dropped = 1;
                else begin
                    e_stored = 1; e_idx = 5'(tgt);
                    if (m_ie[tgt]) e_irq[tgt] = 1'b1;
                end
            end
            for (int i = 0; i < 32; i++) if (dn_clr[i]) m_dn[i] = 0;
            if (tgt >= 0) begin
                m_dn[tgt] = 1; m_rid[tgt] = rx_id; m_ride[tgt] = rx_ide;
                m_dlc[tgt] = rx_dlc; m_data[tgt] = rx_data;
            end
            if (cfg_we) begin
                m_type[cfg_idx] = cfg_type; m_cid[cfg_idx] = cfg_id; m_cide[cfg_idx] = cfg_ide;
                m_msel[cfg_idx] = cfg_msel; m_ie[cfg_idx] = cfg_ie; m_dn[cfg_idx] = 0;
            end
            if (mask_we) m_mask[mask_idx] = mask_val;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the reference (R3 R4 R7 R8)
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R8 rx_stored", rx_stored, e_stored);
            chk("R8 rx_dropped", rx_dropped, e_dropped);
            chk("R7 rx_irq", rx_irq, e_irq);
            if (e_stored) chk("R3 rx_idx", rx_idx, e_idx);
            chk("R4 rd_dn", rd_dn, m_dn[rd_idx]);
            if (m_dn[rd_idx]) begin
                chk("R4 rd_id", rd_id, m_rid[rd_idx]);
                chk("R4 rd_dlc", rd_dlc, m_dlc[rd_idx]);
                chk("R4 rd_data", rd_data, m_data[rd_idx]);
            end
        end
    end

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            compared++; mismatched++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            summary();
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cfg_buf(int idx, int typ, logic [28:0] id, logic ide, int ms, logic ie);
        cfg_we = 1; cfg_idx = 5'(idx); cfg_type = 2'(typ); cfg_id = id;
        cfg_ide = ide; cfg_msel = 2'(ms); cfg_ie = ie;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_mask(int k, logic [28:0] v);
        mask_we = 1; mask_idx = 2'(k); mask_val = v;
        @(negedge clk);
        mask_we = 0;
    endtask

    task automatic send(logic [28:0] id, logic ide, logic [3:0] dlc, logic [63:0] d, logic [31:0] clr);
        rx_valid = 1; rx_id = id; rx_ide = ide; rx_dlc = dlc; rx_data = d; dn_clr = clr;
        @(negedge clk);
        rx_valid = 0; dn_clr = 0;
    endtask

    task automatic expect_store(string tag, int idx);
        chk({tag, " stored"}, rx_stored, 1);
        chk({tag, " index"}, rx_idx, 64'(idx));
    endtask

    task automatic peek_dn(string tag, int idx, logic exp);
        rd_idx = 5'(idx); #1;
        chk(tag, rd_dn, exp);
    endtask

    localparam logic [28:0] EXT_A = 29'h1234567;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        live = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 stored after reset", rx_stored, 0);
        chk("R1 irq after reset", rx_irq, 0);
        peek_dn("R1 dn after reset", 10, 0);

        set_mask(1, 29'h3);
        // class 1 extended group on 10, 12, 13 (non-adjacent), IE on 13 only
        cfg_buf(10, 1, EXT_A, 1, 0, 0);
        cfg_buf(12, 1, EXT_A, 1, 0, 0);
        cfg_buf(13, 1, EXT_A, 1, 0, 1);
        cfg_buf(20, 2, EXT_A, 1, 0, 1);    // other class, same identifier
        cfg_buf(11, 1, 29'h0AAAAAA, 1, 0, 0);
        // class 3 standard group with differing raw IDs under mask 1
        cfg_buf(3, 3, 29'h101, 0, 1, 0);
        cfg_buf(7, 3, 29'h102, 0, 1, 1);

        send(EXT_A, 1, 4'd8, 64'h1111, 0);
        expect_store("R3 first", 10);
        send(EXT_A, 1, 4'd8, 64'h2222, 0);
        expect_store("R3 skip 11", 12);
        send(EXT_A, 1, 4'd8, 64'h3333, 0);
        expect_store("R3 last", 13);
        chk("R7 full irq", rx_irq, 32'h1 << 13);
        rd_idx = 12; #1;
        chk("R4 readback", rd_data, 64'h2222);
        send(EXT_A, 1, 4'd8, 64'h4444, 0);
        chk("R5 no wrap dropped", rx_dropped, 1);
        peek_dn("R6 other class untouched", 20, 0);
        rd_idx = 10; #1;
        chk("R4 not overwritten", rd_data, 64'h1111);

        send(29'h103, 0, 4'd2, 64'hAB, 0);
        expect_store("R2 masked std", 3);
        chk("R7 no irq without IE", rx_irq, 0);
        send(29'h100, 0, 4'd2, 64'hCD, 0);
        expect_store("R2 masked std second", 7);
        send(29'h103, 1, 4'd2, 64'hEF, 0);
        chk("R11 format mismatch dropped", rx_dropped, 1);

        // R9: clear in the same cycle as a frame; frame still sees old flag
        send(EXT_A, 1, 4'd1, 64'h5555, 32'h1 << 12);
        chk("R9 same-cycle clear dropped", rx_dropped, 1);
        send(EXT_A, 1, 4'd1, 64'h6666, 0);
        expect_store("R9 refilled slot", 12);
        send(29'h0, 0, 4'd0, 64'h0, 32'h1 << 10);
        send(EXT_A, 1, 4'd1, 64'h7777, 0);
        expect_store("R9 original position", 10);

        // R10: reconfiguring clears the flag
        cfg_buf(13, 1, EXT_A, 1, 0, 1);
        peek_dn("R10 cfg clears dn", 13, 0);
        send(EXT_A, 1, 4'd1, 64'h8888, 0);
        expect_store("R10 reused", 13);

        // random phase checked by the reference every clock
        for (int n = 0; n < 600; n++) begin
            logic [2:0] pick;
            pick = 3'($urandom_range(0, 5));
            rd_idx = 5'($urandom);
            rx_valid = ($urandom_range(0, 3) != 0);
            case (pick)
                0, 1: begin rx_id = EXT_A; rx_ide = 1; end
                2: begin rx_id = 29'h100 | 29'($urandom_range(0, 3)); rx_ide = 0; end
                3: begin rx_id = 29'h0AAAAAA; rx_ide = 1; end
                default: begin rx_id = 29'($urandom); rx_ide = 1'($urandom); end
            endcase
            rx_dlc = 4'($urandom); rx_data = {32'($urandom), 32'($urandom)};
            dn_clr = ($urandom_range(0, 2) == 0) ? (32'h1 << $urandom_range(0, 31)) : 0;
            cfg_we = ($urandom_range(0, 40) == 0);
            cfg_idx = 5'($urandom_range(10, 13)); cfg_type = 1; cfg_id = EXT_A;
            cfg_ide = 1; cfg_msel = 0; cfg_ie = 1'($urandom);
            @(negedge clk);
        end
        rx_valid = 0; dn_clr = 0; cfg_we = 0;
        @(negedge clk);
        summary();
    end
endmodule